// File: doc/BRIEF.md
# Framed Voice PCM Serial Port with Companding

This block connects the digital side of a voice converter pair to a serial link that carries one sample per frame in each direction. A frame begins when the frame sync rises, and each frame holds sixteen bit-clock periods. In the send direction the block takes the parallel 16-bit two's complement sample from the converter and shifts it out MSB first. It can send the sample as a linear word, or compress it to an 8-bit mu-law or A-law code. In the receive direction it shifts in a serial word and, once per frame, presents a 16-bit linear sample. A received code is expanded back to linear first.

Each direction has its own pair of selects: one chooses linear or companded framing, the other chooses the law. A mute input replaces the outgoing sample with silence in the chosen format. The whole block runs on the master clock, which runs at 256 times the frame rate. The bit clock and the frame sync come in as inputs that are synchronous to that master clock, and the block samples them on its edges.

Top module: `pcm_voice_port`

## Requirements
- R1: A synchronous, active-high reset drives `sdout` low and clears `dac_sample` to zero.
- R2: After a rising edge of `fsync`, the k-th falling edge of `bck` (k = 0..15) puts bit 15-k of the outgoing word on `sdout`, MSB first. A linear word (`adc_cmp_sel` = 0) is the 16-bit two's complement `adc_sample`.
- R3: When `adc_cmp_sel` is 1, the 8-bit code goes out on falling edges 0..7, code bit 7 first, and `sdout` is 0 on falling edges 8..15.
- R4: When `dac_cmp_sel` is 0, the level of `sdin` at the k-th falling edge becomes bit 15-k of the received word. `dac_sample` takes the word just after the 16th edge and holds it until the next update.
- R5: When `dac_cmp_sel` is 1, only edges 0..7 are captured, code bit 7 first. `dac_sample` updates just after edge 7, and the `sdin` levels on edges 8..15 have no effect.
- R6: mu-law (`*_alaw_sel` = 0) encoding works as follows. Shift the sample arithmetically right by 2 and take its magnitude, clipped to 8159. Add 33 to get v. The segment s is the smallest value in 0..7 with v < 64·2^s. The code is {sign, s, v>>(s+1) mod 16} with all bits inverted, where sign is 1 for negative. If v reaches 8192, the 7 low bits are 0x7F before inversion.
- R7: A-law (`*_alaw_sel` = 1) encoding works as follows. Let q = sample >>> 3, and set m = q when q ≥ 0 and m = -q-1 otherwise. The segment s is the smallest value with m < 32·2^s. The mantissa is (m>>1) mod 16 when s < 2 and (m>>s) mod 16 otherwise. If m ≥ 4096, the 7 low bits are 0x7F. Bit 7 is 1 for q ≥ 0, and the 7 low bits are XORed with 0x55.
- R8: A mu-law code c is expanded as follows. Let u = ~c, e = u[6:4] and t = u[3:0]. The magnitude is 4·((2t+33)·2^e) − 132, and the result is negative when u[7] = 1.
- R9: An A-law code c is expanded as follows. Let a = c ^ 0x55, e = a[6:4] and t = a[3:0]. The magnitude is 16t+8 when e = 0 and (2t+33)·2^(e+2) otherwise. The result is positive when a[7] = 1.
- R10: While `adc_mute` is high at the frame start, the frame carries silence: linear 0, mu-law code 0xFF, or A-law code 0xD5.
- R11: `adc_sample`, `adc_mute` and all four selects are captured at the frame-sync rise. Changing them during the frame does not alter the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the frame rate |
| rst | input | 1 | Synchronous reset, active high |
| bck | input | 1 | Bit clock, 16 periods per frame |
| fsync | input | 1 | Frame sync; its rising edge starts a frame |
| adc_sample | input | 16 | Outgoing parallel sample, two's complement |
| adc_mute | input | 1 | Send silence instead of the sample |
| adc_cmp_sel | input | 1 | Send format: 0 linear, 1 companded |
| adc_alaw_sel | input | 1 | Send law: 0 mu-law, 1 A-law |
| dac_cmp_sel | input | 1 | Receive format: 0 linear, 1 companded |
| dac_alaw_sel | input | 1 | Receive law: 0 mu-law, 1 A-law |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial send data |
| dac_sample | output | 16 | Received sample, linear two's complement |

## Verification
The bench expands every one of the 256 codes under both laws through the serial receive path. An expander with an off-by-one segment shift, or with the wrong sign convention, would be caught on whole rows of codes. The bench also sweeps the send sample across the full 16-bit range under both laws, with extra small magnitudes around zero. This exposes a missing clip at the top segment and a wrong rounding of negative values in the A-law path. Other frames put noise in the eight unused receive slots, or change the sample and mute inputs in the middle of a frame. A design that captured too many bits, or that encoded the live input instead of the latched one, would show a corrupted word.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  parameter int SAMPLE_W = 16;
  parameter int CODE_W   = 8;
  localparam int SLOT_W  = $clog2(SAMPLE_W + 1);

  function automatic logic [CODE_W-1:0] mu_encode(input logic signed [SAMPLE_W-1:0] s);
    int q, m, v, seg;
    logic [CODE_W-1:0] raw, mask;
    q = int'(s) >>> 2;
    if (q < 0) begin m = -q; mask = 8'h7F; end
    else       begin m = q;  mask = 8'hFF; end
    if (m > 8159) m = 8159;
    v = m + 33;
    seg = 8;
    for (int i = 7; i >= 0; i--) if (v < (64 << i)) seg = i;
    if (seg == 8) raw = 8'h7F;
    else raw = 8'((seg << 4) | ((v >> (seg + 1)) & 15));
    return raw ^ mask;
  endfunction

  function automatic logic [CODE_W-1:0] alaw_encode(input logic signed [SAMPLE_W-1:0] s);
    int q, m, seg;
    logic [CODE_W-1:0] raw, mask;
    q = int'(s) >>> 3;
    if (q >= 0) begin m = q;      mask = 8'hD5; end
    else        begin m = -q - 1; mask = 8'h55; end
    seg = 8;
    for (int i = 7; i >= 0; i--) if (m < (32 << i)) seg = i;
    if (seg == 8)     raw = 8'h7F;
    else if (seg < 2) raw = 8'((seg << 4) | ((m >> 1) & 15));
    else              raw = 8'((seg << 4) | ((m >> seg) & 15));
    return raw ^ mask;
  endfunction

  function automatic logic [SAMPLE_W-1:0] mu_decode(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] u;
    int t;
    u = ~c;
    t = ((int'(u[3:0]) << 3) + 132) << u[6:4];
    return u[7] ? SAMPLE_W'(132 - t) : SAMPLE_W'(t - 132);
  endfunction

  function automatic logic [SAMPLE_W-1:0] alaw_decode(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] a;
    int t, e;
    a = c ^ 8'h55;
    e = int'(a[6:4]);
    t = int'(a[3:0]) << 4;
    if (e == 0) t = t + 8;
    else        t = (t + 264) << (e - 1);
    return a[7] ? SAMPLE_W'(t) : SAMPLE_W'(-t);
  endfunction

  function automatic logic [SAMPLE_W-1:0] build_tx_word(input logic [SAMPLE_W-1:0] s,
      input logic mute, input logic cmp, input logic alaw);
    logic [CODE_W-1:0] c;
    if (!cmp) return mute ? '0 : s;
    if (mute) c = alaw ? 8'hD5 : 8'hFF;
    else      c = alaw ? alaw_encode(s) : mu_encode(s);
    return {c, {(SAMPLE_W - CODE_W){1'b0}}};
  endfunction
endpackage

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic sig,
  output logic edge_o
);
  logic prev;
  always_ff @(posedge clk) prev <= sig;
  generate
    if (RISING) begin : g_rise
      assign edge_o = sig & ~prev;
    end else begin : g_fall
      assign edge_o = ~sig & prev;
    end
  endgenerate
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_rise,
  input  logic              bck_fall,
  output logic              slot_strobe,
  output logic [SLOT_W-1:0] slot_idx
);
  localparam logic [SLOT_W-1:0] IDLE_CNT = SLOT_W'(SAMPLE_W);
  logic [SLOT_W-1:0] cnt;

  assign slot_strobe = bck_fall & ~fs_rise & (cnt != IDLE_CNT);
  assign slot_idx    = cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= IDLE_CNT;
    else if (fs_rise)     cnt <= '0;
    else if (slot_strobe) cnt <= cnt + 1'b1;
  end

  // R2
  slot_start_chk: assert property (@(posedge clk) disable iff (rst)
    fs_rise |=> (slot_idx == '0));
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                fs_rise,
  input  logic                slot_strobe,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                mute,
  input  logic                cmp_sel,
  input  logic                alaw_sel,
  output logic                sdout
);
  localparam logic [SLOT_W-1:0] HALF_IDX = SLOT_W'(CODE_W);
  logic [SAMPLE_W-1:0] shreg;
  logic                cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cmp_q <= 1'b0;
      sdout <= 1'b0;
    end else if (fs_rise) begin
      shreg <= build_tx_word(sample, mute, cmp_sel, alaw_sel);
      cmp_q <= cmp_sel;
    end else if (slot_strobe) begin
      sdout <= shreg[SAMPLE_W-1];
      shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !sdout);
  // R3
  cmp_tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_strobe && cmp_q && slot_idx >= HALF_IDX) |=> !sdout);
  // R10
  mute_silence_chk: assert property (@(posedge clk) disable iff (rst)
    (fs_rise && mute && !cmp_sel) |=> (shreg == '0));
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                fs_rise,
  input  logic                slot_strobe,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic                sdin,
  input  logic                cmp_sel,
  input  logic                alaw_sel,
  output logic [SAMPLE_W-1:0] dac_sample
);
  localparam logic [SLOT_W-1:0] LAST_LIN = SLOT_W'(SAMPLE_W - 1);
  localparam logic [SLOT_W-1:0] LAST_CMP = SLOT_W'(CODE_W - 1);
  logic [SAMPLE_W-1:0] shreg;
  logic                cmp_q, alaw_q, load_q;
  logic                last_slot;

  assign last_slot = slot_strobe && (slot_idx == (cmp_q ? LAST_CMP : LAST_LIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0; cmp_q <= 1'b0; alaw_q <= 1'b0; load_q <= 1'b0; dac_sample <= '0;
    end else begin
      load_q <= last_slot;
      if (fs_rise) begin
        cmp_q  <= cmp_sel;
        alaw_q <= alaw_sel;
      end else if (slot_strobe) begin
        shreg <= {shreg[SAMPLE_W-2:0], sdin};
      end
      if (load_q) begin
        if (!cmp_q)     dac_sample <= shreg;
        else if (alaw_q) dac_sample <= alaw_decode(shreg[CODE_W-1:0]);
        else             dac_sample <= mu_decode(shreg[CODE_W-1:0]);
      end
    end
  end

  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_q |=> $stable(dac_sample));
  // R5
  cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_strobe && cmp_q && slot_idx == LAST_CMP) |=> load_q);
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                bck,
  input  logic                fsync,
  input  logic [SAMPLE_W-1:0] adc_sample,
  input  logic                adc_mute,
  input  logic                adc_cmp_sel,
  input  logic                adc_alaw_sel,
  input  logic                dac_cmp_sel,
  input  logic                dac_alaw_sel,
  input  logic                sdin,
  output logic                sdout,
  output logic [SAMPLE_W-1:0] dac_sample
);
  logic              fs_rise, bck_fall, slot_strobe;
  logic [SLOT_W-1:0] slot_idx;

  pcm_edge_detect #(.RISING(1'b1)) u_fs_edge (.clk(clk), .sig(fsync), .edge_o(fs_rise));
  pcm_edge_detect #(.RISING(1'b0)) u_bck_edge (.clk(clk), .sig(bck), .edge_o(bck_fall));

  pcm_slot_timer u_timer (
    .clk(clk), .rst(rst), .fs_rise(fs_rise), .bck_fall(bck_fall),
    .slot_strobe(slot_strobe), .slot_idx(slot_idx));

  pcm_tx_path u_tx (
    .clk(clk), .rst(rst), .fs_rise(fs_rise), .slot_strobe(slot_strobe),
    .slot_idx(slot_idx), .sample(adc_sample), .mute(adc_mute),
    .cmp_sel(adc_cmp_sel), .alaw_sel(adc_alaw_sel), .sdout(sdout));

  pcm_rx_path u_rx (
    .clk(clk), .rst(rst), .fs_rise(fs_rise), .slot_strobe(slot_strobe),
    .slot_idx(slot_idx), .sdin(sdin), .cmp_sel(dac_cmp_sel),
    .alaw_sel(dac_alaw_sel), .dac_sample(dac_sample));
endmodule

// File: tb/pcm_voice_port_tb.sv
module pcm_voice_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst, bck, fsync, adc_mute, adc_cmp_sel, adc_alaw_sel, dac_cmp_sel, dac_alaw_sel, sdin;
  logic [15:0] adc_sample;
  logic        sdout;
  logic [15:0] dac_sample;
  int total = 0, fails = 0;
  bit finished = 1'b0;
  logic [15:0] prev_dac = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_voice_port u_dut (
    .clk(clk), .rst(rst), .bck(bck), .fsync(fsync), .adc_sample(adc_sample),
    .adc_mute(adc_mute), .adc_cmp_sel(adc_cmp_sel), .adc_alaw_sel(adc_alaw_sel),
    .dac_cmp_sel(dac_cmp_sel), .dac_alaw_sel(dac_alaw_sel), .sdin(sdin),
    .sdout(sdout), .dac_sample(dac_sample));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int top_bit(input int v);
    int r = -1;
    for (int i = 0; i < 31; i++) if ((v >> i) & 1) r = i;
    return r;
  endfunction

  // R6 restated: magnitude and segment from the leading one
  function automatic logic [7:0] ref_mu(input int x);
    int q = x >>> 2;
    bit neg = (q < 0);
    int m = neg ? -q : q;
    int v, seg;
    logic [6:0] body;
    if (m > 8159) m = 8159;
    v = m + 33;
    if (v >= 8192) body = 7'h7F;
    else begin
      seg = top_bit(v) - 5;
      body = 7'(seg * 16 + ((v / (2 << seg)) % 16));
    end
    return {~neg, ~body};
  endfunction

  // R7 restated
  function automatic logic [7:0] ref_alaw(input int x);
    int q = x >>> 3;
    bit neg = (q < 0);
    int m = neg ? (-q - 1) : q;
    int seg;
    logic [6:0] body;
    if (m >= 4096) body = 7'h7F;
    else begin
      seg = (m < 32) ? 0 : top_bit(m) - 4;
      body = 7'(seg * 16 + ((seg < 2) ? ((m / 2) % 16) : ((m / (1 << seg)) % 16)));
    end
    return {~neg, body ^ 7'h55};
  endfunction

  // R8 restated
  function automatic logic [15:0] ref_mu_dec(input logic [7:0] c);
    logic [7:0] u = ~c;
    int mag = 4 * ((2 * int'(u[3:0]) + 33) << u[6:4]) - 132;
    return u[7] ? 16'(-mag) : 16'(mag);
  endfunction

  // R9 restated
  function automatic logic [15:0] ref_alaw_dec(input logic [7:0] c);
    logic [7:0] a = c ^ 8'h55;
    int e = int'(a[6:4]);
    int mag = (e == 0) ? (16 * int'(a[3:0]) + 8) : ((2 * int'(a[3:0]) + 33) << (e + 2));
    return a[7] ? 16'(mag) : 16'(-mag);
  endfunction

  function automatic logic [15:0] exp_tx(input logic [15:0] s, input logic mute,
      input logic cmp, input logic alaw);
    logic [7:0] c;
    if (!cmp) return mute ? 16'h0 : s;
    if (mute) c = alaw ? 8'hD5 : 8'hFF;
    else c = alaw ? ref_alaw(int'($signed(s))) : ref_mu(int'($signed(s)));
    return {c, 8'h00};
  endfunction

  task automatic run_frame(input logic [15:0] txs, input logic mute, input logic acmp,
      input logic aalaw, input logic dcmp, input logic dalaw, input logic [15:0] rxw,
      input bit change_mid, input string tag);
    logic [15:0] got = '0;
    logic [15:0] exp_t = exp_tx(txs, mute, acmp, aalaw);
    logic [15:0] exp_r;
    if (!dcmp) exp_r = rxw;
    else exp_r = dalaw ? ref_alaw_dec(rxw[15:8]) : ref_mu_dec(rxw[15:8]);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      bck = 1'b1;
      sdin = rxw[15 - n];
      if (n == 0) begin
        fsync = 1'b1; adc_sample = txs; adc_mute = mute;
        adc_cmp_sel = acmp; adc_alaw_sel = aalaw; dac_cmp_sel = dcmp; dac_alaw_sel = dalaw;
      end
      if (n == 8) fsync = 1'b0;
      if (change_mid && n == 4) begin
        adc_sample = ~txs; adc_mute = ~mute; adc_cmp_sel = ~acmp; dac_cmp_sel = ~dcmp;
      end
      repeat (8) @(negedge clk);
      bck = 1'b0;
      repeat (4) @(negedge clk);
      got[15 - n] = sdout;
      if (n == 10) begin
        if (dcmp) check({"R5 early update ", tag}, dac_sample, exp_r);
        else      check({"R4 hold ", tag}, dac_sample, prev_dac);
      end
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    check({"R2/R3 sent word ", tag}, got, exp_t);
    check({"R4/R5 received ", tag}, dac_sample, exp_r);
    prev_dac = exp_r;
  endtask

  initial begin
    rst = 1'b1; bck = 1'b0; fsync = 1'b0; sdin = 1'b0; adc_sample = '0; adc_mute = 1'b0;
    adc_cmp_sel = 1'b0; adc_alaw_sel = 1'b0; dac_cmp_sel = 1'b0; dac_alaw_sel = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 reset sdout", {15'b0, sdout}, 16'h0);
    check("R1 reset dac_sample", dac_sample, 16'h0);
    rst = 1'b0;
    // R2 R4: linear both ways, corners then a spread
    run_frame(16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h7FFF, 1'b0, "lin min");
    run_frame(16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8000, 1'b0, "lin max");
    run_frame(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, "lin -1");
    for (int i = 0; i < 8; i++)
      run_frame(16'(i * 8191 + 5), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'(i * 4099 + 77),
                1'b0, "lin sweep");
    // R6 R8: mu-law send sweep, every receive code, noise in unused slots
    for (int i = 0; i < 256; i++)
      run_frame(16'(i * 257 - 32768), 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                {8'(i), 8'(i * 29 + 7)}, 1'b0, "mu");
    // R7 R9: A-law
    for (int i = 0; i < 256; i++)
      run_frame(16'(32767 - i * 257), 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                {8'(i), 8'(i * 53 + 11)}, 1'b0, "alaw");
    // R6 R7: small magnitudes near zero
    for (int k = 0; k < 12; k++) begin
      run_frame(16'((k % 2 ? -1 : 1) * k * k * 3), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                16'(k), 1'b0, "mu small");
      run_frame(16'((k % 2 ? -1 : 1) * k * k * 3), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
                16'(k), 1'b0, "alaw small");
    end
    // R10: mute in each format
    run_frame(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5555, 1'b0, "R10 mute lin");
    run_frame(16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hAAAA, 1'b0, "R10 mute mu");
    run_frame(16'hC234, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 1'b0, "R10 mute alaw");
    // R11: inputs changed mid-frame
    run_frame(16'h2468, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1357, 1'b1, "R11 lin");
    run_frame(16'hA468, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h3C99, 1'b1, "R11 cmp");
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule